// File: doc/BRIEF.md
# SPI Master Serial-Clock Rate Generator

This block sets the serial clock rate of an SPI master. It runs on the system clock and is configured through one 8-bit setting that software may read or write in any cycle. The setting holds two fields: a linear preselect P (0 to 7) and an exponent select S (0 to 7). Together they fix a bit period of (P + 1) × 2^(S + 1) system clocks, which covers 2 to 2048 clocks per serial bit. The block emits a one-cycle toggle strobe at each half period. The transfer engine uses these strobes to flip its serial clock line.

The strobes run only while the master is enabled and the transfer engine reports a transfer in progress. If a write changes either field during such a transfer, the block sends the engine a one-cycle abort pulse. It then stays silent until the engine drops its busy flag. A write that leaves both fields unchanged does not disturb the transfer. Each new transfer starts the two-stage divisor from zero, so the first strobe arrives exactly one half period after it begins.

Top module: `spi_baud_gen`

## Requirements
- R1: The preselect field P is written from and read back on bits 6:4, and the select field S on bits 2:0.
- R2: Bits 7 and 3 always read as zero, and writes to them have no effect (writing 0xFF reads back as 0x77).
- R3: After reset the setting reads 0x00, abort and strobe are low, and a transfer produces a strobe on every clock (divisor 2).
- R4: While running, consecutive toggle strobes are exactly (P + 1) × 2^S clocks apart, so a full serial bit takes (P + 1) × 2^(S + 1) clocks.
- R5: Settings that yield the same divisor, for example P=1,S=0 and P=0,S=1, produce identical strobe timing.
- R6: No strobe is emitted while master_en is low or busy is low.
- R7: A write that changes P or S while master_en and busy are high raises abort for exactly one cycle, on the clock after the write. From then on no strobe is emitted until busy has dropped and risen again.
- R8: A write of the value already held, during a transfer, raises no abort and does not shift the strobe timing.
- R9: A write while busy is low, or while master_en is low, raises no abort.
- R10: When busy rises with master_en high, the first strobe appears (P + 1) × 2^S clocks later, counted from the first clock at which busy is sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the rate setting |
| wr_data | input | 8 | Write data: P on bits 6:4, S on bits 2:0 |
| rd_data | output | 8 | Current setting, reserved bits read as zero |
| master_en | input | 1 | High when the SPI operates as master |
| busy | input | 1 | High while the transfer engine runs a transfer |
| sck_toggle | output | 1 | One-cycle strobe at each serial clock half period |
| abort | output | 1 | One-cycle pulse: setting changed mid-transfer |

## Verification
The bench builds the block with its default field widths of three bits each. At these widths all 64 field combinations can be visited: every strobe interval from 1 to 1024 clocks is measured against the formula, and every aliased divisor is covered. The small widths also keep the longest half period short enough that the abort, same-value-write and idle cases can each be run as a complete transfer. This includes the halted interval that follows an abort.

// File: rtl/spi_baud_pkg.sv
package spi_baud_pkg;
  localparam int DATA_W  = 8;
  localparam int PRE_W   = 3;
  localparam int SEL_W   = 3;
  localparam int PRE_LSB = 4;
  localparam int SEL_LSB = 0;
  // power-of-two stage counts up to 2**(2**SEL_W - 1) prescale ticks
  localparam int CNT_W   = (1 << SEL_W) - 1;
endpackage

// File: rtl/spi_baud_reg.sv
module spi_baud_reg
  import spi_baud_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [PRE_W-1:0]  pre,
  output logic [SEL_W-1:0]  sel,
  output logic              chg
);
  logic [PRE_W-1:0] pre_new;
  logic [SEL_W-1:0] sel_new;

  assign pre_new = wr_data[PRE_LSB +: PRE_W];
  assign sel_new = wr_data[SEL_LSB +: SEL_W];
  assign chg     = wr_en && ((pre_new != pre) || (sel_new != sel));

  always_ff @(posedge clk) begin
    if (rst) begin
      pre <= '0;
      sel <= '0;
    end else if (wr_en) begin
      pre <= pre_new;
      sel <= sel_new;
    end
  end
endmodule

// File: rtl/spi_baud_prescale.sv
module spi_baud_prescale
  import spi_baud_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [PRE_W-1:0] pre,
  output logic             hit
);
  logic [PRE_W-1:0] pc;

  assign hit = !clr && (pc >= pre);

  always_ff @(posedge clk) begin
    if (rst || clr)  pc <= '0;
    else if (hit)    pc <= '0;
    else             pc <= pc + 1'b1;
  end

  // R4: linear stage never runs past the preselect value
  p_pc_bound_r4: assert property (@(posedge clk) disable iff (rst)
    !clr |-> pc <= pre);
endmodule

// File: rtl/spi_baud_pow2.sv
module spi_baud_pow2
  import spi_baud_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             hit,
  input  logic [SEL_W-1:0] sel,
  output logic             strobe
);
  logic [CNT_W-1:0] qc;
  logic [CNT_W-1:0] lim;

  assign lim = ~({CNT_W{1'b1}} << sel);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      qc     <= '0;
      strobe <= 1'b0;
    end else begin
      strobe <= 1'b0;
      if (hit) begin
        if (qc == lim) begin
          qc     <= '0;
          strobe <= 1'b1;
        end else begin
          qc <= qc + 1'b1;
        end
      end
    end
  end

  // R4: a strobe always follows a prescale tick
  p_strobe_after_tick_r4: assert property (@(posedge clk) disable iff (rst)
    strobe |-> $past(hit));
endmodule

// File: rtl/spi_baud_gen.sv
module spi_baud_gen
  import spi_baud_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              master_en,
  input  logic              busy,
  output logic              sck_toggle,
  output logic              abort
);
  logic [PRE_W-1:0] pre;
  logic [SEL_W-1:0] sel;
  logic             chg;
  logic             halted_q;
  logic             active;
  logic             abort_hit;
  logic             clr;
  logic             hit;

  spi_baud_reg u_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .pre(pre), .sel(sel), .chg(chg)
  );

  assign active    = master_en && busy && !halted_q;
  assign abort_hit = active && chg;
  assign clr       = !active || abort_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      halted_q <= 1'b0;
      abort    <= 1'b0;
    end else begin
      abort <= abort_hit;
      if (!busy)          halted_q <= 1'b0;
      else if (abort_hit) halted_q <= 1'b1;
    end
  end

  always_comb begin
    rd_data = '0;
    rd_data[PRE_LSB +: PRE_W] = pre;
    rd_data[SEL_LSB +: SEL_W] = sel;
  end

  spi_baud_prescale u_pre (
    .clk(clk), .rst(rst), .clr(clr), .pre(pre), .hit(hit)
  );

  spi_baud_pow2 u_pow (
    .clk(clk), .rst(rst), .clr(clr), .hit(hit), .sel(sel), .strobe(sck_toggle)
  );

  // R7: abort lasts a single cycle
  p_abort_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    abort |=> !abort);
  // R7/R9: abort only follows a write during an active master transfer
  p_abort_cause_r9: assert property (@(posedge clk) disable iff (rst)
    abort |-> $past(wr_en && master_en && busy));
  // R8: rewriting the held value never aborts
  p_same_no_abort_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[PRE_LSB +: PRE_W] == pre && wr_data[SEL_LSB +: SEL_W] == sel)
      |=> !abort);
  // R6: no strobe without an enabled, busy master
  p_no_strobe_idle_r6: assert property (@(posedge clk) disable iff (rst)
    (!master_en || !busy) |=> !sck_toggle);
  // R7: the abort cycle carries no strobe
  p_abort_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    abort |-> !sck_toggle);
  // R2: reserved bits read as zero
  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (rd_data[7] == 1'b0 && rd_data[3] == 1'b0));
endmodule

// File: tb/spi_baud_gen_tb.sv
`timescale 1ns/1ps
module spi_baud_gen_tb;
  localparam int CLK_NS = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       master_en = 1'b1;
  logic       busy = 1'b0;
  logic       sck_toggle;
  logic       abort;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  spi_baud_gen u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .master_en(master_en), .busy(busy), .sck_toggle(sck_toggle), .abort(abort)
  );

  // directed vectors: {write data, expected read-back, expected half period}
  localparam int NV = 8;
  localparam logic [31:0] VEC [NV] = '{
    {8'h00, 8'h00, 16'd1},
    {8'h10, 8'h10, 16'd2},
    {8'h01, 8'h01, 16'd2},
    {8'h07, 8'h07, 16'd128},
    {8'h70, 8'h70, 16'd8},
    {8'h32, 8'h32, 16'd16},
    {8'hFF, 8'h77, 16'd1024},
    {8'h88, 8'h00, 16'd1}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // writes with busy low, then starts a transfer and measures the strobes
  task automatic measure(input logic [7:0] d, input int h, input string req);
    int n, f, s, ab;
    wr(d);
    busy = 1'b1;
    n = 0; f = 0; s = 0; ab = 0;
    while (s == 0 && n < 5000) begin
      @(negedge clk);
      n++;
      if (abort) ab++;
      if (sck_toggle) begin
        if (f == 0) f = n; else s = n;
      end
    end
    check(f == h, {req, " first strobe"}, f, h);
    check(s - f == h, {req, " strobe spacing"}, s - f, h);
    check(ab == 0, "R9 no abort on idle write", ab, 0);
    busy = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R3: reset state
    check(rd_data == 8'h00, "R3 reset read", rd_data, 0);
    check(abort == 1'b0, "R3 reset abort", abort, 0);
    check(sck_toggle == 1'b0, "R3 reset strobe", sck_toggle, 0);
    begin
      int n, f, s;
      busy = 1'b1; n = 0; f = 0; s = 0;
      while (s == 0 && n < 100) begin
        @(negedge clk); n++;
        if (sck_toggle) begin if (f == 0) f = n; else s = n; end
      end
      check(f == 1 && s == 2, "R3 divisor 2 after reset", s - f, 1);
      busy = 1'b0; @(negedge clk);
    end

    // R1/R2: directed table
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][31:24]);
      check(rd_data == VEC[i][23:16], "R1 R2 read-back", rd_data, VEC[i][23:16]);
      measure(VEC[i][31:24], int'(VEC[i][15:0]), "R4");
    end

    // R4/R10: every field combination
    for (int p = 0; p < 8; p++) begin
      for (int s = 0; s < 8; s++) begin
        measure(8'((p << 4) | s), (p + 1) << s, "R4 R10");
      end
    end

    // R5: aliased divisors give identical timing
    measure(8'h10, 2, "R5 P1S0");
    measure(8'h01, 2, "R5 P0S1");
    measure(8'h32, 16, "R5 P3S2");
    measure(8'h14, 32, "R5 P1S4");

    // R6: no strobes with master disabled, or idle
    begin
      int cnt;
      wr(8'h00);
      master_en = 1'b0; busy = 1'b1; cnt = 0;
      repeat (20) begin @(negedge clk); if (sck_toggle) cnt++; end
      check(cnt == 0, "R6 master disabled", cnt, 0);
      master_en = 1'b1; busy = 1'b0; cnt = 0;
      repeat (20) begin @(negedge clk); if (sck_toggle) cnt++; end
      check(cnt == 0, "R6 idle", cnt, 0);
    end

    // R9: write with busy high but master disabled
    begin
      int ab;
      master_en = 1'b0; busy = 1'b1; ab = 0;
      wr(8'h55);
      repeat (3) begin if (abort) ab++; @(negedge clk); end
      check(ab == 0, "R9 write, master disabled", ab, 0);
      busy = 1'b0; master_en = 1'b1; @(negedge clk);
    end

    // R7: changing the setting mid-transfer
    begin
      int cnt;
      wr(8'h32);
      busy = 1'b1;
      repeat (5) @(negedge clk);
      wr(8'h21);
      check(abort == 1'b1, "R7 abort raised", abort, 1);
      check(rd_data == 8'h21, "R7 new setting taken", rd_data, 8'h21);
      @(negedge clk);
      check(abort == 1'b0, "R7 abort one cycle", abort, 0);
      cnt = 0;
      repeat (40) begin if (sck_toggle || abort) cnt++; @(negedge clk); end
      check(cnt == 0, "R7 halted while busy held", cnt, 0);
      busy = 1'b0; @(negedge clk);
      measure(8'h21, 6, "R7 R10 restart");
    end

    // R8: rewriting the same value mid-transfer
    begin
      int n, f, ab;
      wr(8'h21);
      busy = 1'b1; n = 0; f = 0; ab = 0;
      while (f == 0 && n < 100) begin
        @(negedge clk); n++;
        if (abort) ab++;
        if (sck_toggle) f = n;
        if (n == 3) begin wr_en = 1'b1; wr_data = 8'h21; end
        else wr_en = 1'b0;
      end
      wr_en = 1'b0;
      check(ab == 0, "R8 no abort", ab, 0);
      check(f == 6, "R8 timing undisturbed", f, 6);
      busy = 1'b0; @(negedge clk);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(negedge clk);
    if (!done) begin
      vectors++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule